// File: doc/BRIEF.md
# System Control Coprocessor Register File

This block holds the state a processor's system control coprocessor exposes through its register-transfer instructions. Each access names a register with four selector fields: a 3-bit first opcode, a 4-bit primary register number, a 4-bit secondary register number and a 3-bit second opcode. Reads return either fixed identification words or the contents of one of three writable registers. The writable registers are a control word, a data tightly-coupled-memory (TCM) region word and an instruction TCM region word.

Every writable register applies its own forced-zero and forced-one masks when it is written, so some bits can never change. The block also turns each TCM region word into a region base address and a byte size. An address decoder next to the memories uses those two outputs directly. A selection that names no register returns zero and raises a one-cycle flag, so the pipeline can take an undefined-instruction trap.

Top module: `syscop_regfile`

## Requirements
- R1: After reset the control word reads 0x00052078, the data TCM word reads 0x0300000A and the instruction TCM word reads 0x00000020.
- R2: With first opcode, primary and secondary numbers all zero, a read returns 0x41059461 for second opcode 0, 0x0F0D2112 for second opcode 1, 0x00140180 for second opcode 2, and 0x41059461 for second opcode 3 to 7.
- R3: The control word sits at selection (0, 1, 0, 0) in the order first opcode, primary, secondary, second opcode. A write to it stores (value AND 0x000FF0FD) OR 0x00000078.
- R4: The data TCM word sits at selection (0, 9, 1, 0). A write to it stores value AND 0xFFFFF03E.
- R5: The instruction TCM word sits at selection (0, 9, 1, 1). A write to it stores value AND 0x0000003E.
- R6: Read data follows the selection in the same cycle. A write lands on the clock edge where the write strobe is high and is visible from the next cycle. With the strobe low, the write data changes nothing.
- R7: For each TCM region, the size code is bits [5:1] of its word, clamped to the range 3 to 23. The size output is 512 shifted left by the clamped code, truncated to 32 bits, so code 23 gives 0, which stands for the whole 4 GiB space. The output follows the word in the cycle after a write.
- R8: Each region base output is bits [31:12] of its word with the low 12 bits zero. The instruction region base is therefore always zero.
- R9: A read of a selection not listed in R2 to R5 returns zero. A write to any selection other than R3 to R5, identification words included, changes no register. Either access sets `undef_access` high for exactly the one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_op1 | input | 3 | First opcode field of the access |
| sel_crn | input | 4 | Primary register number |
| sel_crm | input | 4 | Secondary register number |
| sel_op2 | input | 3 | Second opcode field |
| rd_en | input | 1 | Read access strobe |
| wr_en | input | 1 | Write access strobe |
| wr_data | input | 32 | Value to write |
| rd_data | output | 32 | Selected register value, combinational |
| undef_access | output | 1 | Unmapped access seen in the previous cycle |
| dtcm_base | output | 32 | Data region base address |
| dtcm_size | output | 32 | Data region size in bytes |
| itcm_base | output | 32 | Instruction region base address |
| itcm_size | output | 32 | Instruction region size in bytes |

## Verification
Read data has no register in its path, so the bench checks it one nanosecond after the selection is driven, in the same cycle. A write, along with the region base and size that depend on it, becomes visible after one clock edge. The undefined-access flag is also registered and appears one edge after the access. The bench applies every access at a falling edge and checks those results just after the next rising edge. It then updates its reference model, and the idle step that follows confirms that the flag has dropped again.

// File: rtl/syscop_pkg.sv
package syscop_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ID_MAIN,
    SEL_ID_CACHE,
    SEL_ID_TCM,
    SEL_CTRL,
    SEL_DTCM,
    SEL_ITCM
  } sel_e;

  localparam logic [DW-1:0] ID_MAIN_WORD  = 32'h4105_9461;
  localparam logic [DW-1:0] ID_CACHE_WORD = 32'h0F0D_2112;
  localparam logic [DW-1:0] ID_TCM_WORD   = 32'h0014_0180;

  localparam logic [DW-1:0] CTRL_RST   = 32'h0005_2078;
  localparam logic [DW-1:0] CTRL_ZERO  = 32'hFFF0_0F02;
  localparam logic [DW-1:0] CTRL_ONE   = 32'h0000_0078;
  localparam logic [DW-1:0] DTCM_RST   = 32'h0300_000A;
  localparam logic [DW-1:0] DTCM_ZERO  = 32'h0000_0FC1;
  localparam logic [DW-1:0] ITCM_RST   = 32'h0000_0020;
  localparam logic [DW-1:0] ITCM_ZERO  = 32'hFFFF_FFC1;
endpackage

// File: rtl/syscop_sel_decode.sv
module syscop_sel_decode
  import syscop_pkg::*;
(
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output sel_e       sel
);
  always_comb begin
    sel = SEL_NONE;
    if (op1 == 3'd0) begin
      if (crn == 4'd0 && crm == 4'd0) begin
        case (op2)
          3'd1:    sel = SEL_ID_CACHE;
          3'd2:    sel = SEL_ID_TCM;
          default: sel = SEL_ID_MAIN;
        endcase
      end else if (crn == 4'd1 && crm == 4'd0 && op2 == 3'd0) begin
        sel = SEL_CTRL;
      end else if (crn == 4'd9 && crm == 4'd1) begin
        if (op2 == 3'd0)      sel = SEL_DTCM;
        else if (op2 == 3'd1) sel = SEL_ITCM;
      end
    end
  end
endmodule

// File: rtl/syscop_mask_reg.sv
module syscop_mask_reg #(
  parameter int            W     = 32,
  parameter logic [W-1:0]  RST   = '0,
  parameter logic [W-1:0]  ZMASK = '0,
  parameter logic [W-1:0]  OMASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = (d & ~ZMASK) | OMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_nxt;
  end

  // R3
  forced_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((q & ZMASK) == '0) && ((q & OMASK) == OMASK));

  // R6
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/syscop_tcm_region.sv
module syscop_tcm_region #(
  parameter int W         = 32,
  parameter int CODE_LSB  = 1,
  parameter int CW        = 5,
  parameter int CODE_LO   = 3,
  parameter int CODE_HI   = 23,
  parameter int UNIT_LOG2 = 9,
  parameter int BASE_LSB  = 12
) (
  input  logic [W-1:0] word,
  output logic [W-1:0] base,
  output logic [W-1:0] size
);
  localparam int             AW = $clog2(W) + 2;
  localparam logic [CW-1:0]  LO = CW'(CODE_LO);
  localparam logic [CW-1:0]  HI = CW'(CODE_HI);

  logic [CW-1:0] code_raw, code;
  logic [AW-1:0] shamt;

  always_comb begin
    code_raw = word[CODE_LSB +: CW];
    if (code_raw < LO)      code = LO;
    else if (code_raw > HI) code = HI;
    else                    code = code_raw;
    shamt = AW'(code) + AW'(UNIT_LOG2);
    if (shamt >= AW'(W)) size = '0;
    else                 size = W'(1) << shamt;
    base = {word[W-1:BASE_LSB], {BASE_LSB{1'b0}}};
  end
endmodule

// File: rtl/syscop_regfile.sv
module syscop_regfile
  import syscop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  sel_op1,
  input  logic [3:0]  sel_crn,
  input  logic [3:0]  sel_crm,
  input  logic [2:0]  sel_op2,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        undef_access,
  output logic [31:0] dtcm_base,
  output logic [31:0] dtcm_size,
  output logic [31:0] itcm_base,
  output logic [31:0] itcm_size
);
  sel_e         sel;
  logic         rd_hit, wr_hit, undef_nxt;
  logic [DW-1:0] ctrl_q, dtcm_q, itcm_q;
  logic         we_ctrl, we_dtcm, we_itcm;

  syscop_sel_decode u_dec (
    .op1(sel_op1), .crn(sel_crn), .crm(sel_crm), .op2(sel_op2), .sel(sel)
  );

  always_comb begin
    rd_hit  = (sel != SEL_NONE);
    wr_hit  = (sel == SEL_CTRL) || (sel == SEL_DTCM) || (sel == SEL_ITCM);
    we_ctrl = wr_en && (sel == SEL_CTRL);
    we_dtcm = wr_en && (sel == SEL_DTCM);
    we_itcm = wr_en && (sel == SEL_ITCM);
  end

  syscop_mask_reg #(.W(DW), .RST(CTRL_RST), .ZMASK(CTRL_ZERO), .OMASK(CTRL_ONE))
    u_ctrl (.clk(clk), .rst_n(rst_n), .we(we_ctrl), .d(wr_data), .q(ctrl_q));
  syscop_mask_reg #(.W(DW), .RST(DTCM_RST), .ZMASK(DTCM_ZERO), .OMASK('0))
    u_dtcm (.clk(clk), .rst_n(rst_n), .we(we_dtcm), .d(wr_data), .q(dtcm_q));
  syscop_mask_reg #(.W(DW), .RST(ITCM_RST), .ZMASK(ITCM_ZERO), .OMASK('0))
    u_itcm (.clk(clk), .rst_n(rst_n), .we(we_itcm), .d(wr_data), .q(itcm_q));

  syscop_tcm_region #(.W(DW)) u_dreg (.word(dtcm_q), .base(dtcm_base), .size(dtcm_size));
  syscop_tcm_region #(.W(DW)) u_ireg (.word(itcm_q), .base(itcm_base), .size(itcm_size));

  always_comb begin
    case (sel)
      SEL_ID_MAIN:  rd_data = ID_MAIN_WORD;
      SEL_ID_CACHE: rd_data = ID_CACHE_WORD;
      SEL_ID_TCM:   rd_data = ID_TCM_WORD;
      SEL_CTRL:     rd_data = ctrl_q;
      SEL_DTCM:     rd_data = dtcm_q;
      SEL_ITCM:     rd_data = itcm_q;
      default:      rd_data = '0;
    endcase
  end

  always_comb undef_nxt = (rd_en && !rd_hit) || (wr_en && !wr_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) undef_access <= 1'b0;
    else        undef_access <= undef_nxt;
  end

  // R9
  undef_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_access |-> $past(rd_en || wr_en));

  // R9
  unmapped_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |-> (rd_data == '0));

  // R8
  itcm_base_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    itcm_base == '0);

  // R7
  size_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dtcm_size) && $onehot0(itcm_size) &&
    (dtcm_size == '0 || dtcm_size >= 32'h1000) &&
    (itcm_size == '0 || itcm_size >= 32'h1000));
endmodule

// File: tb/tb_syscop_regfile.sv
`timescale 1ns/1ps
module tb_syscop_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  sel_op1;
  logic [3:0]  sel_crn, sel_crm;
  logic [2:0]  sel_op2;
  logic        rd_en, wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data, dtcm_base, dtcm_size, itcm_base, itcm_size;
  logic        undef_access;

  int total = 0;
  int bad   = 0;
  logic [31:0] m_ctrl, m_dtcm, m_itcm;

  always #2.5 clk = ~clk;

  syscop_regfile dut (
    .clk(clk), .rst_n(rst_n), .sel_op1(sel_op1), .sel_crn(sel_crn),
    .sel_crm(sel_crm), .sel_op2(sel_op2), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .undef_access(undef_access),
    .dtcm_base(dtcm_base), .dtcm_size(dtcm_size),
    .itcm_base(itcm_base), .itcm_size(itcm_size)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_size(input logic [31:0] w);
    int c;
    c = int'(w[5:1]);
    if (c < 3) c = 3;
    if (c > 23) c = 23;
    if (c + 9 >= 32) return 32'h0;
    return 32'h1 << (c + 9);
  endfunction

  function automatic logic [32:0] f_read(input logic [2:0] o1, input logic [3:0] n,
                                         input logic [3:0] m, input logic [2:0] o2);
    if (o1 != 0) return 33'h0;
    if (n == 0 && m == 0) begin
      if (o2 == 1) return {1'b1, 32'h0F0D2112};
      if (o2 == 2) return {1'b1, 32'h00140180};
      return {1'b1, 32'h41059461};
    end
    if (n == 1 && m == 0 && o2 == 0) return {1'b1, m_ctrl};
    if (n == 9 && m == 1 && o2 == 0) return {1'b1, m_dtcm};
    if (n == 9 && m == 1 && o2 == 1) return {1'b1, m_itcm};
    return 33'h0;
  endfunction

  task automatic check_regions();
    chk("R7 dtcm size", dtcm_size, f_size(m_dtcm));
    chk("R7 itcm size", itcm_size, f_size(m_itcm));
    chk("R8 dtcm base", dtcm_base, {m_dtcm[31:12], 12'h0});
    chk("R8 itcm base", itcm_base, 32'h0);
  endtask

  task automatic op(input bit w, input bit r, input logic [2:0] o1, input logic [3:0] n,
                    input logic [3:0] m, input logic [2:0] o2, input logic [31:0] d,
                    input string tag);
    logic [32:0] rr;
    bit whit, exp_undef;
    @(negedge clk);
    sel_op1 = o1; sel_crn = n; sel_crm = m; sel_op2 = o2;
    wr_en = w; rd_en = r; wr_data = d;
    #1;
    rr = f_read(o1, n, m, o2);
    if (r) chk(tag, rd_data, rr[31:0]);
    whit = (o1 == 0) && ((n == 1 && m == 0 && o2 == 0) || (n == 9 && m == 1 && o2 <= 1));
    exp_undef = (r && !rr[32]) || (w && !whit);
    @(posedge clk);
    if (w && whit) begin
      if (n == 1)       m_ctrl = (d & 32'h000FF0FD) | 32'h78;
      else if (o2 == 0) m_dtcm = d & 32'hFFFFF03E;
      else              m_itcm = d & 32'h0000003E;
    end
    #1;
    chk("R9 undef flag", {31'h0, undef_access}, {31'h0, exp_undef});
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; rd_en = 0; wr_en = 0; wr_data = 0;
    sel_op1 = 0; sel_crn = 0; sel_crm = 0; sel_op2 = 0;
    m_ctrl = 32'h00052078; m_dtcm = 32'h0300000A; m_itcm = 32'h00000020;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 undef after reset", {31'h0, undef_access}, 32'h0);
    chk("R7 dtcm reset size", dtcm_size, 32'h00004000);
    chk("R7 itcm reset size", itcm_size, 32'h02000000);
    chk("R8 dtcm reset base", dtcm_base, 32'h03000000);
    // R1 reset contents
    op(0, 1, 0, 1, 0, 0, 0, "R1 ctrl reset");
    op(0, 1, 0, 9, 1, 0, 0, "R1 dtcm reset");
    op(0, 1, 0, 9, 1, 1, 0, "R1 itcm reset");
    // R2 identification words for every second opcode
    for (int k = 0; k < 8; k++) op(0, 1, 0, 0, 0, 3'(k), 0, "R2 id word");
    // R3 forced masks on the control word
    op(1, 0, 0, 1, 0, 0, 32'hFFFFFFFF, "R3 ctrl write");
    op(0, 1, 0, 1, 0, 0, 0, "R3 ctrl all ones");
    op(1, 1, 0, 1, 0, 0, 32'h0, "R3 ctrl write zero");
    op(0, 1, 0, 1, 0, 0, 0, "R3 ctrl zero");
    // R4 data region: code 31 clamps to 23, size wraps to zero
    op(1, 0, 0, 9, 1, 0, 32'hFFFFFFFF, "R4 dtcm write");
    check_regions();
    op(0, 1, 0, 9, 1, 0, 0, "R4 dtcm readback");
    // R7 low clamp: code 0 behaves as 3
    op(1, 0, 0, 9, 1, 0, 32'h12345000, "R4 dtcm code0");
    check_regions();
    chk("R7 low clamp", dtcm_size, 32'h00001000);
    // R5 instruction region base forced to zero
    op(1, 0, 0, 9, 1, 1, 32'hFFFFFFFF, "R5 itcm write");
    op(0, 1, 0, 9, 1, 1, 0, "R5 itcm readback");
    check_regions();
    // R6 strobe low: data ignored
    op(0, 0, 0, 1, 0, 0, 32'h00000000, "R6 idle");
    op(0, 1, 0, 1, 0, 0, 0, "R6 no write");
    // R9 unmapped read, write to id, write with nonzero first opcode
    op(0, 1, 3'd1, 0, 0, 0, 0, "R9 unmapped read");
    op(0, 0, 0, 0, 0, 0, 0, "R9 flag drops");
    op(1, 0, 0, 0, 0, 0, 32'hDEADBEEF, "R9 id write");
    op(1, 0, 3'd2, 1, 0, 0, 32'h0, "R9 op1 write");
    op(0, 1, 0, 1, 0, 0, 0, "R9 ctrl kept");
    op(0, 1, 0, 0, 0, 0, 0, "R9 id kept");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] o1, o2;
      logic [3:0] n, m;
      int pick;
      pick = $urandom_range(0, 9);
      o1 = 0;
      case (pick)
        0: begin n = 1; m = 0; o2 = 0; end
        1: begin n = 9; m = 1; o2 = 0; end
        2: begin n = 9; m = 1; o2 = 1; end
        3: begin n = 0; m = 0; o2 = 3'($urandom); end
        4: begin n = 1; m = 0; o2 = 0; end
        5: begin n = 9; m = 1; o2 = 3'($urandom); end
        default: begin
          o1 = 3'($urandom); n = 4'($urandom); m = 4'($urandom); o2 = 3'($urandom);
        end
      endcase
      op(1'($urandom), 1'($urandom), o1, n, m, o2, $urandom, "R6 random access");
      check_regions();
    end
    op(0, 0, 0, 0, 0, 0, 0, "R6 final idle");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule